// File: doc/BRIEF.md
# Single-Line Command Level Decoder

The block turns a single analog control line that carries several operator commands into clean, qualified command events. An external converter samples the line as a fraction of the supply and delivers an unsigned code. The block sorts each code into one of five commands or into "no command": ON, OFF, RESUME, ACCEL and COAST. A command is accepted only after its band has stayed unchanged for a set number of millisecond ticks. RESUME must be held much longer than the other commands.

Each accepted command produces a single-cycle pulse on its own output. ACCEL and COAST also raise a level that stays high for as long as the line stays in that band after it is accepted. The block keeps an enabled state. An accepted ON sets it and an accepted OFF clears it. RESUME, ACCEL and COAST are only recognised while the block is enabled.

Top module: `cmd_level_decoder`

## Requirements
- R1: A sample equal to the full-scale code (255 with the default 8-bit width) decodes as ON, whether or not the block is enabled.
- R2: While enabled, samples 197..239 decode as RESUME, 133..196 as ACCEL and 64..132 as COAST. While not enabled, those samples decode as no command and produce no pulse.
- R3: Samples 0..30 decode as OFF in either state. Samples 31..63 and 240..254 decode as no command.
- R4: ON, OFF, ACCEL and COAST pulse once the band has been stable for 50 ms ticks. The pulse comes in the cycle after the 50th tick, and no pulse follows the 49th tick.
- R5: RESUME pulses after 330 stable ms ticks, and not after 329.
- R6: Any change of decoded band restarts qualification from zero, so ticks counted in an earlier band never count toward a later one.
- R7: A held command pulses only once. A new pulse needs the line to leave the band and qualify again.
- R8: After reset `enabled` is low. It goes high the cycle after an ON pulse and low the cycle after an OFF pulse.
- R9: `accel_held` and `coast_held` go high together with their command's pulse and stay high until the decoded band changes. They are never high at the same time.
- R10: Each pulse lasts exactly one clock cycle, and at most one pulse output is high in any cycle.
- R11: After reset all pulse and held outputs are low, and any qualification in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| level_sample | input | SAMPLE_W | Digitised line level, 0 = ground, all ones = full supply |
| on_pulse | output | 1 | Qualified ON event |
| off_pulse | output | 1 | Qualified OFF event |
| resume_pulse | output | 1 | Qualified RESUME event |
| accel_pulse | output | 1 | Qualified ACCEL event |
| coast_pulse | output | 1 | Qualified COAST event |
| accel_held | output | 1 | ACCEL accepted and still present |
| coast_held | output | 1 | COAST accepted and still present |
| enabled | output | 1 | System enabled state |

## Verification
A wrong band register or a count that does not restart shows up as a pulse that comes one or more ticks too early or too late. It can also show up as a pulse on the wrong output. This is visible in the cycle after the qualifying tick. A stuck "already fired" flag shows up either as a second pulse while the level is held or as a missing pulse after requalification. A wrong enabled state shows up as RESUME, ACCEL or COAST pulses appearing or disappearing, or as `enabled` itself changing, within one cycle of the ON or OFF pulse. The vectors place samples on both sides of every band edge and tick counts on both sides of each limit, so an off-by-one in either is exposed within that vector.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;
    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_OFF    = 3'd1,
        CMD_COAST  = 3'd2,
        CMD_ACCEL  = 3'd3,
        CMD_RESUME = 3'd4,
        CMD_ON     = 3'd5
    } cmd_e;

    localparam int NCMD = 6;
endpackage

// File: rtl/cmdl_band_classifier.sv
module cmdl_band_classifier
    import cmdl_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic [SAMPLE_W-1:0] level_sample,
    input  logic                enabled,
    output cmd_e                band
);
    localparam longint FULL    = (64'd1 << SAMPLE_W) - 1;
    localparam logic [SAMPLE_W-1:0] EDGE_TOP = SAMPLE_W'((FULL * 94) / 100);
    localparam logic [SAMPLE_W-1:0] EDGE_RES = SAMPLE_W'((FULL * 77) / 100);
    localparam logic [SAMPLE_W-1:0] EDGE_ACC = SAMPLE_W'((FULL * 52) / 100);
    localparam logic [SAMPLE_W-1:0] EDGE_CST = SAMPLE_W'((FULL * 25) / 100);
    localparam logic [SAMPLE_W-1:0] EDGE_OFF = SAMPLE_W'((FULL * 12) / 100);
    localparam logic [SAMPLE_W-1:0] CODE_ON  = '1;

    cmd_e raw_band;

    always_comb begin
        if (level_sample == CODE_ON)       raw_band = CMD_ON;
        else if (level_sample > EDGE_TOP)  raw_band = CMD_NONE;
        else if (level_sample > EDGE_RES)  raw_band = CMD_RESUME;
        else if (level_sample > EDGE_ACC)  raw_band = CMD_ACCEL;
        else if (level_sample > EDGE_CST)  raw_band = CMD_COAST;
        else if (level_sample > EDGE_OFF)  raw_band = CMD_NONE;
        else                               raw_band = CMD_OFF;
    end

    always_comb begin
        band = raw_band;
        if (!enabled && (raw_band == CMD_RESUME || raw_band == CMD_ACCEL ||
                         raw_band == CMD_COAST))
            band = CMD_NONE;
    end
endmodule

// File: rtl/cmdl_qualifier.sv
module cmdl_qualifier
    import cmdl_pkg::*;
#(
    parameter int LIM_SHORT = 50,
    parameter int LIM_LONG  = 330
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ms_tick,
    input  cmd_e            band,
    output logic [NCMD-1:0] fire,
    output cmd_e            cur_band,
    output logic            done
);
    localparam int LIM_MAX = (LIM_LONG > LIM_SHORT) ? LIM_LONG : LIM_SHORT;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);

    typedef struct packed {
        cmd_e             cur;
        logic [CNT_W-1:0] cnt;
        logic             fired;
        logic [NCMD-1:0]  fire;
    } qual_t;

    qual_t st_q, st_d;
    logic [CNT_W-1:0] lim_cur;

    always_comb begin
        lim_cur = (st_q.cur == CMD_RESUME) ? CNT_W'(LIM_LONG) : CNT_W'(LIM_SHORT);
    end

    always_comb begin
        st_d      = st_q;
        st_d.fire = '0;
        if (band != st_q.cur) begin
            st_d.cur   = band;
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (ms_tick && !st_q.fired && st_q.cur != CMD_NONE) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == lim_cur) begin
                st_d.fired = 1'b1;
                st_d.fire[int'(st_q.cur)] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cur   <= CMD_NONE;
            st_q.cnt   <= '0;
            st_q.fired <= 1'b0;
            st_q.fire  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire     = st_q.fire;
    assign cur_band = st_q.cur;
    assign done     = st_q.fired;

    // R4 R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= lim_cur);
    // R10
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.fire));
    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.fire) |=> !(|st_q.fire));
    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (band != st_q.cur) |=> (st_q.cnt == '0 && !st_q.fired));
    // R7
    fired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fired && band == st_q.cur) |=> (st_q.fired && !(|st_q.fire)));
endmodule

// File: rtl/cmdl_mode_tracker.sv
module cmdl_mode_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic on_evt,
    input  logic off_evt,
    output logic enabled
);
    logic en_q, en_d;

    always_comb begin
        en_d = en_q;
        if (on_evt)       en_d = 1'b1;
        else if (off_evt) en_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign enabled = en_q;

    // R8
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(on_evt));
    // R8
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> $past(off_evt));
endmodule

// File: rtl/cmd_level_decoder.sv
module cmd_level_decoder
    import cmdl_pkg::*;
#(
    parameter int SAMPLE_W  = 8,
    parameter int LIM_SHORT = 50,
    parameter int LIM_LONG  = 330
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ms_tick,
    input  logic [SAMPLE_W-1:0] level_sample,
    output logic                on_pulse,
    output logic                off_pulse,
    output logic                resume_pulse,
    output logic                accel_pulse,
    output logic                coast_pulse,
    output logic                accel_held,
    output logic                coast_held,
    output logic                enabled
);
    cmd_e            band;
    cmd_e            cur_band;
    logic [NCMD-1:0] fire;
    logic            done;
    logic            en;

    cmdl_band_classifier #(.SAMPLE_W(SAMPLE_W)) u_class (
        .level_sample(level_sample),
        .enabled     (en),
        .band        (band)
    );

    cmdl_qualifier #(.LIM_SHORT(LIM_SHORT), .LIM_LONG(LIM_LONG)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .band    (band),
        .fire    (fire),
        .cur_band(cur_band),
        .done    (done)
    );

    cmdl_mode_tracker u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .on_evt (fire[int'(CMD_ON)]),
        .off_evt(fire[int'(CMD_OFF)]),
        .enabled(en)
    );

    assign on_pulse     = fire[int'(CMD_ON)];
    assign off_pulse    = fire[int'(CMD_OFF)];
    assign resume_pulse = fire[int'(CMD_RESUME)];
    assign accel_pulse  = fire[int'(CMD_ACCEL)];
    assign coast_pulse  = fire[int'(CMD_COAST)];
    assign accel_held   = done && (cur_band == CMD_ACCEL);
    assign coast_held   = done && (cur_band == CMD_COAST);
    assign enabled      = en;

    // R2
    gated_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_pulse || accel_pulse || coast_pulse) |-> enabled);
    // R9
    held_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accel_held && coast_held));
    // R9
    held_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accel_held) |-> accel_pulse);
endmodule

// File: tb/cmd_level_decoder_test.sv
module cmd_level_decoder_test;
    localparam int C_NONE = 0, C_OFF = 1, C_COAST = 2, C_ACCEL = 3, C_RES = 4, C_ON = 5;
    localparam int NV = 25;
    // {sample[8], ticks[12], expected cmd[3], enabled, accel_held, coast_held}
    localparam logic [25:0] VEC [NV] = '{
        {8'd150, 12'd60,  3'd0, 1'b0, 1'b0, 1'b0}, // R2 gated while disabled
        {8'd255, 12'd49,  3'd0, 1'b0, 1'b0, 1'b0}, // R4 49 ticks
        {8'd255, 12'd1,   3'd5, 1'b1, 1'b0, 1'b0}, // R1 R4 R8
        {8'd255, 12'd60,  3'd0, 1'b1, 1'b0, 1'b0}, // R7
        {8'd150, 12'd50,  3'd3, 1'b1, 1'b1, 1'b0}, // R2 R9
        {8'd150, 12'd20,  3'd0, 1'b1, 1'b1, 1'b0}, // R7 R9
        {8'd100, 12'd30,  3'd0, 1'b1, 1'b0, 1'b0}, // R6 R9
        {8'd150, 12'd30,  3'd0, 1'b1, 1'b0, 1'b0}, // R6
        {8'd100, 12'd50,  3'd2, 1'b1, 1'b0, 1'b1}, // R2 R6 R9
        {8'd45,  12'd100, 3'd0, 1'b1, 1'b0, 1'b0}, // R3
        {8'd200, 12'd329, 3'd0, 1'b1, 1'b0, 1'b0}, // R5
        {8'd200, 12'd1,   3'd4, 1'b1, 1'b0, 1'b0}, // R5
        {8'd239, 12'd10,  3'd0, 1'b1, 1'b0, 1'b0}, // R2 R7
        {8'd240, 12'd60,  3'd0, 1'b1, 1'b0, 1'b0}, // R3
        {8'd197, 12'd330, 3'd4, 1'b1, 1'b0, 1'b0}, // R2 R5
        {8'd196, 12'd50,  3'd3, 1'b1, 1'b1, 1'b0}, // R2
        {8'd133, 12'd5,   3'd0, 1'b1, 1'b1, 1'b0}, // R2
        {8'd132, 12'd50,  3'd2, 1'b1, 1'b0, 1'b1}, // R2
        {8'd64,  12'd5,   3'd0, 1'b1, 1'b0, 1'b1}, // R2
        {8'd63,  12'd60,  3'd0, 1'b1, 1'b0, 1'b0}, // R3
        {8'd30,  12'd50,  3'd1, 1'b0, 1'b0, 1'b0}, // R3 R8
        {8'd200, 12'd330, 3'd0, 1'b0, 1'b0, 1'b0}, // R2 disabled
        {8'd31,  12'd60,  3'd0, 1'b0, 1'b0, 1'b0}, // R3
        {8'd0,   12'd50,  3'd1, 1'b0, 1'b0, 1'b0}, // R3 OFF while disabled
        {8'd254, 12'd60,  3'd0, 1'b0, 1'b0, 1'b0}  // R3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic [7:0] level_sample = 8'd45;
    logic on_pulse, off_pulse, resume_pulse, accel_pulse, coast_pulse;
    logic accel_held, coast_held, enabled;

    int n_cmp = 0;
    int n_bad = 0;
    int seen [6];
    int cycles = 0;

    always #4 clk = ~clk;

    cmd_level_decoder uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .level_sample(level_sample),
        .on_pulse(on_pulse), .off_pulse(off_pulse), .resume_pulse(resume_pulse),
        .accel_pulse(accel_pulse), .coast_pulse(coast_pulse),
        .accel_held(accel_held), .coast_held(coast_held), .enabled(enabled)
    );

    always @(negedge clk) begin
        if (on_pulse)     seen[C_ON]++;
        if (off_pulse)    seen[C_OFF]++;
        if (resume_pulse) seen[C_RES]++;
        if (accel_pulse)  seen[C_ACCEL]++;
        if (coast_pulse)  seen[C_COAST]++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_seen();
        for (int i = 0; i < 6; i++) seen[i] = 0;
    endtask

    task automatic apply(input logic [7:0] s);
        @(negedge clk);
        level_sample = s;
        @(posedge clk);
        @(posedge clk);
        clear_seen();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic check_counts(input string req, input int exp_cmd);
        for (int c = 1; c < 6; c++)
            check(req, seen[c], (c == exp_cmd) ? 1 : 0);
    endtask

    initial begin
        clear_seen();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11 on", int'(on_pulse), 0);
        check("R11 accel_held", int'(accel_held), 0);
        check("R11 coast_held", int'(coast_held), 0);
        check("R8 reset enabled", int'(enabled), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][25:18]);
            ticks(int'(VEC[v][17:6]));
            check_counts($sformatf("vec%0d pulses R4 R5 R7 R10", v), int'(VEC[v][5:3]));
            check($sformatf("vec%0d R8 enabled", v), int'(enabled), int'(VEC[v][2]));
            check($sformatf("vec%0d R9 accel_held", v), int'(accel_held), int'(VEC[v][1]));
            check($sformatf("vec%0d R9 coast_held", v), int'(coast_held), int'(VEC[v][0]));
        end

        // R11 reset mid-qualification discards progress
        apply(8'd255);
        ticks(25);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        clear_seen();
        ticks(25);
        check_counts("R11 restart after reset", C_NONE);
        ticks(25);
        check_counts("R1 R11 ON after full 50", C_ON);

        // R6 brief excursion into another band restarts the count
        apply(8'd150);
        ticks(40);
        apply(8'd100);
        apply(8'd150);
        ticks(40);
        check_counts("R6 excursion restart", C_NONE);
        ticks(10);
        check_counts("R6 R9 accel after restart", C_ACCEL);
        check("R9 accel_held level", int'(accel_held), 1);

        // R9 held level drops the cycle after the band changes
        @(negedge clk);
        level_sample = 8'd45;
        @(negedge clk);
        check("R9 held drop", int'(accel_held), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule